// File: doc/BRIEF.md
# Configuration Access Address Encoder

This block turns a configuration request (bus number, device/function byte and register offset) into the two values a host bridge needs before it can run a configuration cycle through a 16 MB aperture. The first value is the 24-bit address inside the aperture. The second is a 16-bit window-map word that carries the cycle-type code and, for some device slots, the device-select bit. Accesses to bus zero are encoded as type 0 cycles for the local segment. Every other bus number gives a type 1 cycle that the downstream bridges forward.

Type 0 accesses select their target with a one-hot device-select bit. The aperture address has room for that bit only up to slot 12. Slots 13 to 20 get their bit in the map word, whose bits 15..4 stand for address bits 31..20. Slots 21 to 31 have no position in either value, so they get no select bit at all.

Requests enter on a valid/ready port and results leave on a valid/ready port, with one register stage between them. A request is taken on any clock edge where `req_valid` and `req_ready` are both high. The result appears on the next cycle. While the consumer holds `rsp_ready` low and a result is pending, the result stays frozen and `req_ready` stays low. A pending result that is consumed can be replaced by a new request on the same edge.

Top module: `cfg_addr_gen`

## Requirements
- R1: A request with bus number 0 produces a type 0 result (map bit 0 = 0). Any other bus number produces a type 1 result (map bit 0 = 1).
- R2: Every result carries the configuration cycle code 3'b101 in map bits 3..1, and zeros in map bits 7..4.
- R3: In a type 0 result, the function number (device/function bits 2..0) sits in address bits 10..8 and the register offset in address bits 7..0.
- R4: In a type 0 result with slot (device/function bits 7..3) of 12 or less, address bit (slot + 11) is the only select bit, and map bits 15..8 are zero.
- R5: In a type 0 result with slot 13 to 20, map bit (slot - 5) is the only select bit, and address bits 23..11 are zero.
- R6: In a type 0 result with slot 21 to 31, address bits 23..11 and map bits 15..8 are all zero.
- R7: In a type 1 result, the address is {bus, device/function, offset} in bits 23..16, 15..8 and 7..0, and map bits 15..4 are zero.
- R8: `req_ready` equals (not `rsp_valid`) or `rsp_ready`, and a request accepted at an edge is presented with `rsp_valid` high right after that edge.
- R9: While `rsp_valid` is high and `rsp_ready` is low, `rsp_addr` and `rsp_map` hold their values and no request is accepted.
- R10: After reset, `rsp_valid` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_bus | input | 8 | Target bus number |
| req_devfn | input | 8 | Device (bits 7..3) and function (bits 2..0) |
| req_offset | input | 8 | Configuration register offset |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer accepts the result |
| rsp_addr | output | 24 | Address inside the configuration aperture |
| rsp_map | output | 16 | Window-map word with cycle type and high select bit |

## Verification
The bench sweeps every device/function byte against several bus numbers and offsets. This makes the slot 12/13 split and the slot 20/21 split both visible. Off-by-one errors in either split would show up in the sweep: a design that pushes the select bit past address bit 23 loses it, and a design that puts slots 21 and above into map bits beyond its range wraps into the type field. A design that tests the bus number on the wrong bits, or that drops the offset or the function field, fails on the type 1 patterns, where every byte is visible in the address. A back-pressure sequence checks that a stalled result is not overwritten by a waiting request, and that the waiting request is taken on the very edge the stalled result is consumed.

// File: rtl/cfg_addr_pkg.sv
package cfg_addr_pkg;
  localparam int DEVFN_W = 8;
  localparam int FUNC_W  = 3;
  localparam int SLOT_W  = DEVFN_W - FUNC_W;
  localparam logic [2:0] CYC_CONFIG = 3'b101;
  typedef enum logic {
    SEG_LOCAL  = 1'b0,
    SEG_REMOTE = 1'b1
  } seg_e;
endpackage

// File: rtl/cfg_local_enc.sv
module cfg_local_enc
  import cfg_addr_pkg::*;
#(
  parameter int OFS_W        = 8,
  parameter int APER_W       = 24,
  parameter int MAP_W        = 16,
  parameter int MAP_BASE_BIT = 16
) (
  input  logic [DEVFN_W-1:0] devfn,
  input  logic [OFS_W-1:0]   ofs,
  output logic [APER_W-1:0]  addr,
  output logic [MAP_W-1:0]   map
);
  localparam int IDSEL_LSB = OFS_W + FUNC_W;
  localparam int SPLIT     = APER_W - 1 - IDSEL_LSB;
  localparam int NSLOT     = 1 << SLOT_W;
  localparam int MAP_LOW   = 4;

  logic [SLOT_W-1:0] slot;
  logic [FUNC_W-1:0] func;
  logic [APER_W-1:0] amask [NSLOT];
  logic [MAP_W-1:0]  mmask [NSLOT];

  assign slot = devfn[DEVFN_W-1:FUNC_W];
  assign func = devfn[FUNC_W-1:0];

  // Each slot gets a constant select mask, placed in the address when it fits
  // the aperture, else in the map word when it fits there, else nowhere.
  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    localparam int MIDX = s + IDSEL_LSB - MAP_BASE_BIT;
    if (s <= SPLIT) begin : g_in_addr
      assign amask[s] = APER_W'(1) << (s + IDSEL_LSB);
      assign mmask[s] = '0;
    end else if (MIDX >= MAP_LOW && MIDX < MAP_W) begin : g_in_map
      assign amask[s] = '0;
      assign mmask[s] = MAP_W'(1) << MIDX;
    end else begin : g_none
      assign amask[s] = '0;
      assign mmask[s] = '0;
    end
  end

  assign addr = amask[slot] | (APER_W'(func) << OFS_W) | APER_W'(ofs);
  assign map  = mmask[slot] | MAP_W'({CYC_CONFIG, 1'b0});
endmodule

// File: rtl/cfg_remote_enc.sv
module cfg_remote_enc
  import cfg_addr_pkg::*;
#(
  parameter int BUS_W  = 8,
  parameter int OFS_W  = 8,
  parameter int APER_W = 24,
  parameter int MAP_W  = 16
) (
  input  logic [BUS_W-1:0]   bus,
  input  logic [DEVFN_W-1:0] devfn,
  input  logic [OFS_W-1:0]   ofs,
  output logic [APER_W-1:0]  addr,
  output logic [MAP_W-1:0]   map
);
  assign addr = APER_W'({bus, devfn, ofs});
  assign map  = MAP_W'({CYC_CONFIG, 1'b1});
endmodule

// File: rtl/cfg_hold_stage.sv
module cfg_hold_stage #(
  parameter int W = 40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data <= '0;
    end else if (in_valid && in_ready) begin
      out_data <= in_data;
    end
  end
endmodule

// File: rtl/cfg_addr_gen.sv
module cfg_addr_gen
  import cfg_addr_pkg::*;
#(
  parameter int BUS_W  = 8,
  parameter int OFS_W  = 8,
  parameter int APER_W = 24,
  parameter int MAP_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BUS_W-1:0]  req_bus,
  input  logic [7:0]        req_devfn,
  input  logic [OFS_W-1:0]  req_offset,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [APER_W-1:0] rsp_addr,
  output logic [MAP_W-1:0]  rsp_map
);
  localparam int PAY_W = APER_W + MAP_W;

  seg_e              seg;
  logic [APER_W-1:0] loc_addr, rem_addr, sel_addr;
  logic [MAP_W-1:0]  loc_map, rem_map, sel_map;
  logic [PAY_W-1:0]  pay_out;

  assign seg = (req_bus == '0) ? SEG_LOCAL : SEG_REMOTE;

  cfg_local_enc #(
    .OFS_W(OFS_W), .APER_W(APER_W), .MAP_W(MAP_W), .MAP_BASE_BIT(16)
  ) u_local (
    .devfn(req_devfn), .ofs(req_offset), .addr(loc_addr), .map(loc_map)
  );

  cfg_remote_enc #(
    .BUS_W(BUS_W), .OFS_W(OFS_W), .APER_W(APER_W), .MAP_W(MAP_W)
  ) u_remote (
    .bus(req_bus), .devfn(req_devfn), .ofs(req_offset),
    .addr(rem_addr), .map(rem_map)
  );

  always_comb begin
    if (seg == SEG_LOCAL) begin
      sel_addr = loc_addr;
      sel_map  = loc_map;
    end else begin
      sel_addr = rem_addr;
      sel_map  = rem_map;
    end
  end

  cfg_hold_stage #(.W(PAY_W)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .in_valid(req_valid), .in_ready(req_ready), .in_data({sel_map, sel_addr}),
    .out_valid(rsp_valid), .out_ready(rsp_ready), .out_data(pay_out)
  );

  assign rsp_addr = pay_out[APER_W-1:0];
  assign rsp_map  = pay_out[PAY_W-1:APER_W];
endmodule

// File: rtl/cfg_addr_gen_chk.sv
module cfg_addr_gen_chk #(
  parameter int BUS_W  = 8,
  parameter int OFS_W  = 8,
  parameter int APER_W = 24,
  parameter int MAP_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [BUS_W-1:0]  req_bus,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [APER_W-1:0] rsp_addr,
  input logic [MAP_W-1:0]  rsp_map
);
  localparam int IDSEL_LSB = OFS_W + 3;

  p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_addr) && $stable(rsp_map)));

  p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  p_cyc_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_map[3:1] == 3'b101 && rsp_map[7:4] == 4'd0));

  p_one_select_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_map[0]) |->
      ($countones({rsp_addr[APER_W-1:IDSEL_LSB], rsp_map[MAP_W-1:4]}) <= 1));

  p_segment_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (rsp_map[0] == ($past(req_bus) != '0)));

  p_remote_map_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_map[0]) |-> (rsp_map[MAP_W-1:4] == '0));
endmodule

bind cfg_addr_gen cfg_addr_gen_chk #(
  .BUS_W(BUS_W), .OFS_W(OFS_W), .APER_W(APER_W), .MAP_W(MAP_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_bus(req_bus), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_addr(rsp_addr), .rsp_map(rsp_map)
);

// File: tb/tb_cfg_addr_gen.sv
module tb_cfg_addr_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  req_bus = '0;
  logic [7:0]  req_devfn = '0;
  logic [7:0]  req_offset = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [23:0] rsp_addr;
  logic [15:0] rsp_map;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_addr_gen dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_bus(req_bus), .req_devfn(req_devfn), .req_offset(req_offset),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_addr(rsp_addr), .rsp_map(rsp_map)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Expected {map, addr} from the requirements.
  function automatic logic [39:0] expect_word(input logic [7:0] b, input logic [7:0] df,
                                               input logic [7:0] of);
    logic [23:0] a;
    logic [15:0] m;
    int slot;
    slot = int'(df[7:3]);
    if (b == 8'd0) begin
      a = {13'd0, df[2:0], of};
      m = 16'h000A;
      if (slot <= 12) a = a | (24'd1 << (slot + 11));
      else if (slot <= 20) m = m | (16'd1 << (slot - 5));
    end else begin
      a = {b, df, of};
      m = 16'h000B;
    end
    return {m, a};
  endfunction

  function automatic string tag_of(input logic [7:0] b, input logic [7:0] df);
    if (b != 8'd0) return "R1/R7";
    if (df[7:3] <= 5'd12) return "R1/R3/R4";
    if (df[7:3] <= 5'd20) return "R1/R3/R5";
    return "R1/R3/R6";
  endfunction

  task automatic one_req(input logic [7:0] b, input logic [7:0] df, input logic [7:0] of);
    @(negedge clk);
    req_bus = b; req_devfn = df; req_offset = of; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R8 valid", 64'(rsp_valid), 64'd1);
    check(tag_of(b, df), 64'({rsp_map, rsp_addr}), 64'(expect_word(b, df, of)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] bus_set [4];
    logic [7:0] ofs_set [2];
    logic [39:0] first_w;
    bus_set = '{8'h00, 8'h01, 8'h80, 8'hFF};
    ofs_set = '{8'h00, 8'hFC};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 rsp_valid", 64'(rsp_valid), 64'd0);
    check("R10 req_ready", 64'(req_ready), 64'd1);

    for (int bi = 0; bi < 4; bi++)
      for (int d = 0; d < 256; d++)
        for (int oi = 0; oi < 2; oi++)
          one_req(bus_set[bi], 8'(d), ofs_set[oi] ^ 8'(d));

    // Back-pressure: A stalls, B waits, then both move.
    @(negedge clk);
    rsp_ready = 1'b0;
    req_bus = 8'h00; req_devfn = {5'd14, 3'd2}; req_offset = 8'h10; req_valid = 1'b1;
    first_w = expect_word(8'h00, {5'd14, 3'd2}, 8'h10);
    @(negedge clk);
    check("R8 A accepted", 64'(rsp_valid), 64'd1);
    check("R9 req_ready low", 64'(req_ready), 64'd0);
    req_bus = 8'h05; req_devfn = 8'h3B; req_offset = 8'h44;
    repeat (3) begin
      @(negedge clk);
      check("R9 held", 64'({rsp_map, rsp_addr}), 64'(first_w));
      check("R9 stall", 64'(req_ready), 64'd0);
    end
    rsp_ready = 1'b1;
    #1;
    check("R8 ready on drain", 64'(req_ready), 64'd1);
    @(negedge clk);
    req_valid = 1'b0;
    check("R8 B valid", 64'(rsp_valid), 64'd1);
    check("R7 B value", 64'({rsp_map, rsp_addr}), 64'(expect_word(8'h05, 8'h3B, 8'h44)));
    @(negedge clk);
    check("R8 drained", 64'(rsp_valid), 64'd0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule